// File: doc/BRIEF.md
# Non-Restoring Divide Step Unit

This block performs one step of one-bit-per-step non-restoring division. It holds three state flags. A quotient-sign flag (Q) and a divisor-sign flag (M) select the operation. A transfer flag (T) carries the quotient bit out of each step and feeds it back into the next one.

A controller, outside this block, sets up the flags with one of two initialisation commands. It then issues one step command per quotient bit. On each step it supplies the partial remainder on `rn_i` and the divisor on `rm_i`, and it takes the new partial remainder from `rn_o`. The controller also owns the sequencing and the collection of the quotient bits.

Every command completes on a single clock edge. The flags and the remainder register all update on that same edge.

Top module: `divide_step_unit`

## Requirements
- R1: After the active-low asynchronous reset, `q_o`, `m_o` and `t_o` are 0 and `rn_o` is 0.
- R2: The command code 2'b01 (unsigned init) clears Q, M and T to 0 and leaves `rn_o` unchanged.
- R3: The command code 2'b10 (signed init) loads Q from `rn_i[31]` and M from `rm_i[31]`. It sets T to the XOR of those two bits and leaves `rn_o` unchanged.
- R4: The command code 2'b11 (step) forms a shifted value: `rn_i` shifted left by one, with the current T in bit 0. When the current Q equals M, `rn_o` becomes the shifted value minus `rm_i`, modulo 2^32.
- R5: On a step where the current Q differs from M, `rn_o` becomes the shifted value plus `rm_i`, modulo 2^32.
- R6: After a step, Q equals F XOR `rn_i[31]` XOR M. F is the borrow out of the subtraction or the carry out of the addition, whichever the step performed.
- R7: After a step, T is 1 exactly when the new Q equals M.
- R8: The command code 2'b00 (idle) leaves Q, M, T and `rn_o` unchanged. A step never changes M.
- R9: The result of any command is visible on the outputs one clock edge after the command is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_i | input | 2 | Command: 00 idle, 01 unsigned init, 10 signed init, 11 step |
| rn_i | input | 32 | Partial remainder, or dividend for signed init |
| rm_i | input | 32 | Divisor |
| rn_o | output | 32 | Partial remainder after the last step |
| q_o | output | 1 | Q flag |
| m_o | output | 1 | M flag |
| t_o | output | 1 | T flag |

## Verification
The bench goes after the four combinations of old Q and M, each with and without a carry or borrow.

- A swapped add/subtract choice gives a wrong remainder. A Q update that drops one of its three XOR terms flips the quotient bit.
- The bench steps with `rn_i[31]` set and with `rm_i` set to zero. This catches a design that takes Q from the shifted value rather than from the old top bit, or that miscounts a zero-divisor subtraction as a borrow.
- Runs of consecutive steps check that T is fed back into bit 0. Idle and init commands placed between steps catch a remainder register that is written when it should hold.

// File: rtl/dvs_pkg.sv
package dvs_pkg;
  typedef enum logic [1:0] {
    CMD_IDLE   = 2'b00,
    CMD_INIT_U = 2'b01,
    CMD_INIT_S = 2'b10,
    CMD_STEP   = 2'b11
  } dvs_cmd_e;

  typedef struct packed {
    logic q;
    logic m;
    logic t;
  } dvs_flags_t;
endpackage

// File: rtl/dvs_step_alu.sv
module dvs_step_alu #(
  parameter int unsigned W = 32
) (
  input  logic [W-1:0] rn_i,
  input  logic [W-1:0] rm_i,
  input  logic         q_i,
  input  logic         m_i,
  input  logic         t_i,
  output logic [W-1:0] rn_o,
  output logic         q_o,
  output logic         t_o
);
  localparam int unsigned MSB = W - 1;

  logic [W-1:0] shifted;
  logic [W:0]   sum_ext;
  logic [W:0]   dif_ext;
  logic         do_sub;
  logic         flag;

  assign shifted = {rn_i[MSB-1:0], t_i};
  assign do_sub  = (q_i == m_i);
  assign sum_ext = {1'b0, shifted} + {1'b0, rm_i};
  assign dif_ext = {1'b0, shifted} - {1'b0, rm_i};

  always_comb begin
    if (do_sub) begin
      rn_o = dif_ext[MSB:0];
      flag = dif_ext[W];
    end else begin
      rn_o = sum_ext[MSB:0];
      flag = sum_ext[W];
    end
    q_o = flag ^ rn_i[MSB] ^ m_i;
    t_o = (q_o == m_i);
  end
endmodule

// File: rtl/dvs_state.sv
module dvs_state
  import dvs_pkg::*;
#(
  parameter int unsigned W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  dvs_cmd_e     cmd_i,
  input  logic         rn_msb_i,
  input  logic         rm_msb_i,
  input  logic [W-1:0] step_rn_i,
  input  logic         step_q_i,
  input  logic         step_t_i,
  output logic [W-1:0] rn_o,
  output dvs_flags_t   flags_o
);
  dvs_flags_t   flags_q, flags_d;
  logic [W-1:0] rn_q, rn_d;

  always_comb begin
    flags_d = flags_q;
    rn_d    = rn_q;
    unique case (cmd_i)
      CMD_INIT_U: flags_d = '0;
      CMD_INIT_S: begin
        flags_d.q = rn_msb_i;
        flags_d.m = rm_msb_i;
        flags_d.t = rn_msb_i ^ rm_msb_i;
      end
      CMD_STEP: begin
        flags_d.q = step_q_i;
        flags_d.t = step_t_i;
        rn_d      = step_rn_i;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flags_q <= '0;
      rn_q    <= '0;
    end else begin
      flags_q <= flags_d;
      rn_q    <= rn_d;
    end
  end

  assign flags_o = flags_q;
  assign rn_o    = rn_q;

  assert_init_u_clears_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_i == CMD_INIT_U |=> (flags_q == '0) && $stable(rn_q));
  assert_init_s_signs_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_i == CMD_INIT_S |=> flags_q.m == $past(rm_msb_i) && flags_q.q == $past(rn_msb_i));
  assert_idle_holds_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_i == CMD_IDLE |=> $stable(flags_q) && $stable(rn_q));
  assert_step_keeps_m_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_i == CMD_STEP |=> $stable(flags_q.m));
  assert_step_t_match_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_i == CMD_STEP |=> flags_q.t == (flags_q.q == flags_q.m));
endmodule

// File: rtl/divide_step_unit.sv
module divide_step_unit
  import dvs_pkg::*;
#(
  parameter int unsigned W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [1:0]   cmd_i,
  input  logic [W-1:0] rn_i,
  input  logic [W-1:0] rm_i,
  output logic [W-1:0] rn_o,
  output logic         q_o,
  output logic         m_o,
  output logic         t_o
);
  localparam int unsigned MSB = W - 1;

  dvs_flags_t   flags;
  logic [W-1:0] alu_rn;
  logic         alu_q, alu_t;
  dvs_cmd_e     cmd;

  assign cmd = dvs_cmd_e'(cmd_i);

  dvs_step_alu #(.W(W)) u_alu (
    .rn_i (rn_i),
    .rm_i (rm_i),
    .q_i  (flags.q),
    .m_i  (flags.m),
    .t_i  (flags.t),
    .rn_o (alu_rn),
    .q_o  (alu_q),
    .t_o  (alu_t)
  );

  dvs_state #(.W(W)) u_state (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .cmd_i     (cmd),
    .rn_msb_i  (rn_i[MSB]),
    .rm_msb_i  (rm_i[MSB]),
    .step_rn_i (alu_rn),
    .step_q_i  (alu_q),
    .step_t_i  (alu_t),
    .rn_o      (rn_o),
    .flags_o   (flags)
  );

  assign q_o = flags.q;
  assign m_o = flags.m;
  assign t_o = flags.t;
endmodule

// File: tb/divide_step_unit_tb.sv
module divide_step_unit_tb;
  logic        clk = 0;
  logic        rst_n = 0;
  logic [1:0]  cmd = 2'b00;
  logic [31:0] rn = '0, rm = '0;
  logic [31:0] rn_o;
  logic        q_o, m_o, t_o;

  always #2.5 clk = ~clk;

  divide_step_unit u_dut (
    .clk_i(clk), .rst_ni(rst_n), .cmd_i(cmd), .rn_i(rn), .rm_i(rm),
    .rn_o(rn_o), .q_o(q_o), .m_o(m_o), .t_o(t_o)
  );

  typedef struct {
    int          due;
    logic [31:0] rn;
    logic        q, m, t;
    string       req;
  } exp_t;

  exp_t        sb[$];
  int          cyc = 0;
  int          n_cmp = 0, n_bad = 0;
  logic [31:0] mrn = '0;
  logic        mq = 0, mm = 0, mt = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic compare(exp_t e);
    n_cmp++;
    if (rn_o !== e.rn || q_o !== e.q || m_o !== e.m || t_o !== e.t) begin
      n_bad++;
      $display("FAIL %s: got rn=%h q=%b m=%b t=%b exp rn=%h q=%b m=%b t=%b",
               e.req, rn_o, q_o, m_o, t_o, e.rn, e.q, e.m, e.t);
    end
  endtask

  // monitor: outputs are due one edge after the command (R9)
  always @(negedge clk) begin
    while (sb.size() > 0 && sb[0].due <= cyc) begin
      exp_t e;
      e = sb.pop_front();
      compare(e);
    end
  end

  // driver: drive at negedge, compute expected from requirements
  task automatic issue(input logic [1:0] c, input logic [31:0] a, input logic [31:0] b, input string req);
    exp_t e;
    logic [31:0] sh;
    logic [32:0] wide;
    logic        fl, oq;
    @(negedge clk);
    cmd = c; rn = a; rm = b;
    case (c)
      2'b01: begin mq = 0; mm = 0; mt = 0; end                 // R2
      2'b10: begin mq = a[31]; mm = b[31]; mt = a[31] ^ b[31]; end // R3
      2'b11: begin
        oq = mq;
        sh = {a[30:0], mt};
        if (oq == mm) begin                                    // R4
          wide = {1'b0, sh} - {1'b0, b};
        end else begin                                         // R5
          wide = {1'b0, sh} + {1'b0, b};
        end
        fl  = wide[32];
        mrn = wide[31:0];
        mq  = fl ^ a[31] ^ mm;                                 // R6
        mt  = (mq == mm);                                      // R7
      end
      default: ;                                               // R8 idle
    endcase
    e.due = cyc + 1; e.rn = mrn; e.q = mq; e.m = mm; e.t = mt; e.req = req;
    sb.push_back(e);
  endtask

  initial begin
    #200000;
    n_bad++;
    $display("FAIL watchdog: got hang exp finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #7 rst_n = 1;
    @(negedge clk);
    begin exp_t e; e.due = cyc; e.rn = 0; e.q = 0; e.m = 0; e.t = 0; e.req = "R1 reset"; compare(e); end

    issue(2'b10, 32'h8000_0000, 32'h0000_0005, "R3 signs differ");
    issue(2'b10, 32'h8000_0001, 32'h8000_0003, "R3 both neg");
    issue(2'b00, 32'hFFFF_FFFF, 32'hFFFF_FFFF, "R8 idle after init");
    issue(2'b01, 32'h1234_5678, 32'h9ABC_DEF0, "R2 unsigned init");
    // q==m=0: subtract, no borrow then borrow
    issue(2'b11, 32'h0000_0010, 32'h0000_0003, "R4 sub no borrow");
    issue(2'b11, 32'h0000_0001, 32'h0000_0009, "R4 R6 sub borrow");
    issue(2'b11, 32'h8000_0004, 32'h0000_0001, "R6 msb set");
    issue(2'b11, 32'h4000_0000, 32'h0000_0000, "R4 zero divisor");
    issue(2'b00, 32'h0, 32'h0, "R8 idle holds rn");
    // set q!=m to force add path
    issue(2'b10, 32'h8000_0000, 32'h0000_0007, "R3 setup add");
    issue(2'b11, 32'h7FFF_FFFF, 32'hFFFF_FFF0, "R5 add carry");
    issue(2'b10, 32'h0000_0000, 32'h8000_0007, "R3 setup add2");
    issue(2'b11, 32'h0000_0002, 32'h0000_0003, "R5 add no carry");
    issue(2'b10, 32'h8000_0000, 32'h8000_0000, "R3 q=m=1");
    issue(2'b11, 32'hC000_0000, 32'h8000_0001, "R4 R7 sub q=m=1");
    issue(2'b11, 32'hFFFF_FFFF, 32'hFFFF_FFFF, "R9 back to back");
    for (int i = 0; i < 400; i++) begin
      logic [1:0] c;
      int k = $urandom_range(0, 9);
      c = (k < 7) ? 2'b11 : (k == 7) ? 2'b10 : (k == 8) ? 2'b01 : 2'b00;
      issue(c, $urandom, $urandom, "R6 R7 random");
    end
    issue(2'b00, 32'h0, 32'h0, "R8 final idle");
    @(negedge clk);
    @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule